// File: doc/BRIEF.md
# Legacy Interrupt Latch Controller

This block sits in a chipset bridge and conditions two legacy interrupt sources under the control of one 32-bit general-control register. The first path watches the active-low coprocessor floating-point error input. When that path is enabled, an error raises an internal IRQ13 request and drives the active-low ignore-numeric-error output. Both stay asserted until software performs an I/O write to the coprocessor clear port, F0h.

The second path handles the keyboard interrupt IRQ1 in one of two modes. In latch mode it captures a rising edge and holds the request until the keyboard data port, 60h, is read. In bypass mode it forwards the synchronized level unchanged.

Both raw inputs pass through a synchronizer before use. The I/O decode input carries the address together with single-cycle read and write strobes from the bus side of the bridge. All outputs come from registers, and every rule here uses synchronous, active-high reset.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset the control register reads 00000000h, `irq1_out` and `irq13_out` are 0, and `ignne_n` is 1.
- R2: Only control bits 25, 24, 13 and 12 are writable (mask 03003000h). All other bits read as 0 whatever was written. `reg_rdata` shows a write on the cycle after the write strobe.
- R3: With bit 13 set, holding `ferr_n` low makes `irq13_out` 1 and `ignne_n` 0 on the third rising clock edge after the input changes.
- R4: Once raised, IRQ13 and the ignore-numeric-error output stay active after `ferr_n` returns high. They are released only at the clock edge that samples an I/O write (`io_wr`) with `io_addr` = 00F0h. An I/O read of 00F0h or a write to any other address leaves them set.
- R5: With bit 13 clear, `ferr_n` has no effect on `irq13_out` or `ignne_n`. Clearing bit 13 while a request is pending drops both outputs at the next clock edge.
- R6: If the clearing F0h write and an active error fall on the same cycle, the request stays set.
- R7: With bit 12 set, a rising edge of `irq1_in` sets `irq1_out` on the third rising edge after the input changes. It then stays 1 after `irq1_in` falls, until the edge that samples an I/O read (`io_rd`) of 0060h. A write to 0060h or a read of any other address does not clear it.
- R8: With bit 12 clear, `irq1_out` equals `irq1_in` delayed by three clock edges. Clearing bit 12 drops a latched request at the next edge.
- R9: If a new IRQ1 rising edge and the clearing 0060h read fall on the same cycle, `irq1_out` stays 1.
- R10: In latch mode, only an edge sets the request. An `irq1_in` held high across a clear does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |
| io_addr | input | 16 | I/O cycle address |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_wr | input | 1 | I/O write strobe, one cycle |
| ferr_n | input | 1 | Raw coprocessor error, active low |
| irq1_in | input | 1 | Raw keyboard interrupt |
| irq1_out | output | 1 | Conditioned keyboard interrupt |
| irq13_out | output | 1 | Internal coprocessor error interrupt |
| ignne_n | output | 1 | Ignore numeric error, active low |

## Verification
A pending request held in the wrong state shows on `irq13_out`, `ignne_n` or `irq1_out` within one edge of the clearing access or enable change that should have moved it. A sticky bit that fails to hold shows within a few cycles of the source going inactive. The bench samples at the exact third edge after each input change, so an extra or missing synchronizer stage is caught. It also stages the set-against-clear collisions in the precise cycle where a lost priority would drop the request. A control bit that is stored wrongly shows on the read port on the cycle after the write, and the bench sweeps every bit position to find it.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int CTL_W        = 32;
  localparam int FPE_EN_BIT   = 13;
  localparam int KBD_LAT_BIT  = 12;
  localparam logic [CTL_W-1:0] CTL_WMASK = 32'h0300_3000;

  typedef struct packed {
    logic fpe_en;
    logic kbd_latch_en;
  } lirq_ctl_t;
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= INIT;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/lirq_ctlreg.sv
module lirq_ctlreg
  import lirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output lirq_ctl_t        ctl
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (wr) ctl_q <= wdata & CTL_WMASK;
  end

  assign rdata            = ctl_q;
  assign ctl.fpe_en       = ctl_q[FPE_EN_BIT];
  assign ctl.kbd_latch_en = ctl_q[KBD_LAT_BIT];

  // R2
  wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rdata == ($past(wdata) & CTL_WMASK)));
endmodule

// File: rtl/lirq_fpe_path.sv
module lirq_fpe_path (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic err_act,
  input  logic clr,
  output logic irq13,
  output logic ignne_n
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (!en) pend_q <= 1'b0;
    else          pend_q <= err_act | (pend_q & ~clr);
  end

  assign irq13   = pend_q;
  assign ignne_n = ~pend_q;

  // R3
  fpe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && err_act) |=> irq13);
  // R4
  fpe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (en && irq13 && !clr) |=> irq13);
  // R5
  fpe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!irq13 && ignne_n));
endmodule

// File: rtl/lirq_kbd_path.sv
module lirq_kbd_path (
  input  logic clk,
  input  logic rst,
  input  logic latch_en,
  input  logic irq_s,
  input  logic clr,
  output logic irq1
);
  logic prev_q;
  logic out_q;
  logic rise;

  assign rise = irq_s & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= irq_s;
      if (latch_en) out_q <= rise | (out_q & ~clr);
      else          out_q <= irq_s;
    end
  end

  assign irq1 = out_q;

  // R7
  kbd_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_en && irq1 && !clr) |=> irq1);
  // R8
  kbd_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> (irq1 == $past(irq_s)));
  // R9
  kbd_setwin_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_en && rise) |=> irq1);
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
#(
  parameter int                IO_AW       = 16,
  parameter logic [IO_AW-1:0]  FPE_CLR_IO  = 16'h00F0,
  parameter logic [IO_AW-1:0]  KBD_DATA_IO = 16'h0060,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic             ferr_n,
  input  logic             irq1_in,
  output logic             irq1_out,
  output logic             irq13_out,
  output logic             ignne_n
);
  lirq_ctl_t  ctl;
  logic [1:0] raw_s;
  logic       fpe_clr;
  logic       kbd_clr;

  lirq_ctlreg u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctl   (ctl)
  );

  lirq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b01)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({irq1_in, ferr_n}),
    .q   (raw_s)
  );

  assign fpe_clr = io_wr && (io_addr == FPE_CLR_IO);
  assign kbd_clr = io_rd && (io_addr == KBD_DATA_IO);

  lirq_fpe_path u_fpe (
    .clk     (clk),
    .rst     (rst),
    .en      (ctl.fpe_en),
    .err_act (~raw_s[0]),
    .clr     (fpe_clr),
    .irq13   (irq13_out),
    .ignne_n (ignne_n)
  );

  lirq_kbd_path u_kbd (
    .clk      (clk),
    .rst      (rst),
    .latch_en (ctl.kbd_latch_en),
    .irq_s    (raw_s[1]),
    .clr      (kbd_clr),
    .irq1     (irq1_out)
  );

  // R4
  fpe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq13_out) |-> ($past(fpe_clr) || !$past(ctl.fpe_en)));
endmodule

// File: tb/lirq_ctrl_bench.sv
`timescale 1ns/1ps
module lirq_ctrl_bench;
  localparam logic [31:0] MASK = 32'h0300_3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic        ferr_n = 1'b1;
  logic        irq1_in = 1'b0;
  logic        irq1_out, irq13_out, ignne_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lirq_ctrl u_lirq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .ferr_n(ferr_n), .irq1_in(irq1_in), .irq1_out(irq1_out),
    .irq13_out(irq13_out), .ignne_n(ignne_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic io(input logic [15:0] a, input logic rd, input logic wr);
    io_addr = a; io_rd = rd; io_wr = wr;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irq1", irq1_out, 1'b0);
    chk("R1 irq13", irq13_out, 1'b0);
    chk("R1 ignne_n", ignne_n, 1'b1);

    // R2: every single bit, then all ones
    for (int i = 0; i < 32; i++) begin
      wreg(32'h1 << i);
      chk("R2 bit", reg_rdata, (32'h1 << i) & MASK);
    end
    wreg(32'hFFFF_FFFF);
    chk("R2 ones", reg_rdata, MASK);
    wreg(32'h0);

    // R5: disabled error path ignores ferr_n
    ferr_n = 1'b0; step(5);
    chk("R5 irq13 off", irq13_out, 1'b0);
    chk("R5 ignne off", ignne_n, 1'b1);
    ferr_n = 1'b1; step(3);

    // R3 timing
    wreg(32'h0000_2000); step(1);
    ferr_n = 1'b0; step(2);
    chk("R3 early", irq13_out, 1'b0);
    step(1);
    chk("R3 irq13", irq13_out, 1'b1);
    chk("R3 ignne", ignne_n, 1'b0);
    ferr_n = 1'b1; step(4);
    // R4 sticky and clear decode
    chk("R4 hold", irq13_out, 1'b1);
    io(16'h00F0, 1'b1, 1'b0);
    chk("R4 read F0", irq13_out, 1'b1);
    io(16'h00F1, 1'b0, 1'b1);
    chk("R4 write F1", irq13_out, 1'b1);
    io(16'h00F0, 1'b0, 1'b1);
    chk("R4 clear irq13", irq13_out, 1'b0);
    chk("R4 clear ignne", ignne_n, 1'b1);

    // R6: set wins over clear
    ferr_n = 1'b0; step(4);
    io(16'h00F0, 1'b0, 1'b1);
    chk("R6 set wins", irq13_out, 1'b1);
    ferr_n = 1'b1; step(3);
    io(16'h00F0, 1'b0, 1'b1);
    chk("R6 later clear", irq13_out, 1'b0);

    // R5: clearing enable drops pending
    ferr_n = 1'b0; step(4);
    chk("R5 pending", irq13_out, 1'b1);
    wreg(32'h0); step(1);
    chk("R5 drop irq13", irq13_out, 1'b0);
    chk("R5 drop ignne", ignne_n, 1'b1);
    ferr_n = 1'b1; step(3);

    // R8 bypass with delay sweep
    irq1_in = 1'b1; step(2);
    chk("R8 early", irq1_out, 1'b0);
    step(1);
    chk("R8 high", irq1_out, 1'b1);
    irq1_in = 1'b0; step(2);
    chk("R8 still", irq1_out, 1'b1);
    step(1);
    chk("R8 low", irq1_out, 1'b0);

    // R7 latch
    wreg(32'h0000_1000); step(1);
    irq1_in = 1'b1; step(3);
    chk("R7 set", irq1_out, 1'b1);
    irq1_in = 1'b0; step(5);
    chk("R7 hold", irq1_out, 1'b1);
    io(16'h0060, 1'b0, 1'b1);
    chk("R7 write 60", irq1_out, 1'b1);
    io(16'h0064, 1'b1, 1'b0);
    chk("R7 read 64", irq1_out, 1'b1);
    io(16'h0060, 1'b1, 1'b0);
    chk("R7 clear", irq1_out, 1'b0);

    // R10 level held high does not relatch
    irq1_in = 1'b1; step(3);
    chk("R10 set", irq1_out, 1'b1);
    io(16'h0060, 1'b1, 1'b0);
    chk("R10 cleared", irq1_out, 1'b0);
    step(3);
    chk("R10 no relatch", irq1_out, 1'b0);
    irq1_in = 1'b0; step(3);

    // R9 set wins over read
    irq1_in = 1'b1; step(3);
    irq1_in = 1'b0; step(4);
    chk("R9 pending", irq1_out, 1'b1);
    irq1_in = 1'b1; step(2);
    io(16'h0060, 1'b1, 1'b0);
    chk("R9 set wins", irq1_out, 1'b1);
    io(16'h0060, 1'b1, 1'b0);
    chk("R9 later clear", irq1_out, 1'b0);
    irq1_in = 1'b0; step(3);

    // R8 clearing the latch enable drops a pending request
    irq1_in = 1'b1; step(3);
    irq1_in = 1'b0; step(3);
    chk("R8 pending", irq1_out, 1'b1);
    wreg(32'h0); step(1);
    chk("R8 drop", irq1_out, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule